// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port

This block is a single-channel UART with one transmit holding register, one receive holding register and a 16-bit baud divider. The divider produces a tick every `baud_div + 1` clock cycles. Each serial bit lasts `OVS` ticks. The transmitter sends one start bit, the data bits least significant first, an optional parity bit and one stop bit. The receiver finds the start edge, checks the start bit again half a bit later, and then samples every following bit at its centre.

Data enters and leaves as streams. A transmit byte moves on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high whenever the holding register is empty, so one byte can wait while the shifter sends the previous one. A received byte stays on `rx_data` with `rx_valid` high until a cycle where `rx_ready` is also high. The receiver cannot be stalled. A byte that completes while the previous one has not been taken is dropped and recorded as an overrun.

The format, polarity, interrupt enables and error clear are level inputs on `cfg`. Transmit break has its own pin. The `status` word collects the flags, the line level and a read-back of part of the configuration.

Top module: `aser_port`

## Requirements
- R1: After reset, `ser_out` is 1, `irq` is 0, `rx_valid` is 0, and `status` reads 0x2100 while `ser_in` is held at 1 and `cfg` is 0.
- R2: A transmitted frame is a low start bit, then the data bits LSB first, an optional parity bit and a high stop bit. Each bit lasts `OVS*(baud_div+1)` cycles.
- R3: With `cfg[1]` set, a parity bit follows the data. `cfg[0]`=1 selects odd parity, meaning the data bits plus the parity bit hold an odd number of ones. `cfg[0]`=0 selects even parity.
- R4: `tx_ready` (also `status[8]`) is low while the holding register is full. The holding register empties on the cycle after acceptance if the shifter is idle, so a second byte can be accepted while the first is being sent.
- R5: A received byte appears on `rx_data` with `rx_valid` (also `status[7]`) high. It is held there until `rx_valid && rx_ready`.
- R6: `status[9]` (parity error) sets when parity is enabled and the received parity bit does not match the selected parity.
- R7: `status[10]` (framing error) sets when the stop bit is sampled low. The byte is still delivered.
- R8: `status[11]` (overrun error) sets when a frame completes while `rx_valid` is high and no pop happens in that cycle. The new byte is discarded and `rx_data` keeps the old one.
- R9: `status[15]` is the OR of bits 9 to 11. While `cfg[6]` is high, all three error flags are cleared, and clearing takes priority over setting.
- R10: `cfg[2]` inverts the `ser_out` level. `cfg[3]` inverts `ser_in` before decoding.
- R11: While `tx_break` is high, `ser_out` is held at the space level (0 before inversion, so it equals `cfg[2]`), and `status[14]` reads 1.
- R12: `irq` = (`rx_valid` AND `cfg[5]`) OR (`tx_ready` AND `cfg[4]`).
- R13: `status[4:0]` echo `cfg[4:0]`. `status[13]` is the synchronized, uninverted `ser_in` level. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 7 | Format, polarity, interrupt enable and error-clear settings |
| tx_break | input | 1 | Forces the line to space while high |
| baud_div | input | DIV_W | Baud tick period minus one, in clock cycles |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_data | input | DATA_W | Transmit byte |
| rx_valid | output | 1 | Receive byte held |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | DATA_W | Received byte |
| ser_in | input | 1 | Serial line input |
| ser_out | output | 1 | Serial line output |
| irq | output | 1 | Interrupt request |
| status | output | 16 | Flags, line level and settings read-back |

## Verification
The bench builds the port with `OVS`=8 and the default 16-bit divider. A frame is therefore about 180 cycles at `baud_div`=1, short enough to run many frames, including back-to-back, overrun and bad-stop sequences. It also runs one transmit at `baud_div`=0, where a tick occurs on every cycle. Because each divider tick spans two cycles at `baud_div`=1, the receiver sees start edges that fall between ticks. This exercises the tolerance of the half-bit start check.

// File: rtl/aser_pkg.sv
`timescale 1ns/1ps
package aser_pkg;
  // configuration bit positions
  localparam int CF_ODD    = 0;
  localparam int CF_PAREN  = 1;
  localparam int CF_TXINV  = 2;
  localparam int CF_RXINV  = 3;
  localparam int CF_TXIE   = 4;
  localparam int CF_RXIE   = 5;
  localparam int CF_CLRERR = 6;
  // status bit positions
  localparam int ST_RBF = 7;
  localparam int ST_TBE = 8;
  localparam int ST_PE  = 9;
  localparam int ST_FE  = 10;
  localparam int ST_OE  = 11;
  localparam int ST_PIN = 13;
  localparam int ST_BRK = 14;
  localparam int ST_ERR = 15;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;
endpackage

// File: rtl/aser_tick.sv
`timescale 1ns/1ps
module aser_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == '0)  cnt <= div;
    else                 cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);

  // R2: a nonzero divider spaces ticks apart
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
endmodule

// File: rtl/aser_tx.sv
`timescale 1ns/1ps
module aser_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              line
);
  localparam int FR_W  = DATA_W + 3;
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int CNT_W = $clog2(FR_W + 1);

  logic [DATA_W-1:0] hold;
  logic              hold_full;
  logic              busy;
  logic [FR_W-1:0]   shreg;
  logic [SUB_W-1:0]  sub;
  logic [CNT_W-1:0]  left;
  logic              load;

  assign load     = !busy && hold_full;
  assign in_ready = !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else if (in_valid && !hold_full) begin
      hold      <= in_data;
      hold_full <= 1'b1;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      sub   <= '0;
      left  <= '0;
    end else if (load) begin
      shreg <= {1'b1, (par_en ? (^hold ^ par_odd) : 1'b1), hold, 1'b0};
      left  <= par_en ? CNT_W'(FR_W) : CNT_W'(FR_W - 1);
      sub   <= '0;
      busy  <= 1'b1;
    end else if (busy && tick) begin
      if (sub == SUB_W'(OVS - 1)) begin
        sub   <= '0;
        shreg <= {1'b1, shreg[FR_W-1:1]};
        left  <= left - 1'b1;
        if (left == CNT_W'(1)) busy <= 1'b0;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  assign line = busy ? shreg[0] : 1'b1;

  // R4: a waiting byte is never lost while the shifter is busy
  p_hold_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && busy) |=> hold_full);
  // R2: every frame opens with a low start bit
  p_frame_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !line);
endmodule

// File: rtl/aser_rx.sv
`timescale 1ns/1ps
module aser_rx
  import aser_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              lvl,
  input  logic              pop,
  input  logic              clr,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              pe,
  output logic              fe,
  output logic              oe
);
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam int HALF  = (OVS / 2 > 0) ? OVS / 2 : 1;

  rx_state_e        st;
  logic [SUB_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [DATA_W:0]  bits;
  logic             par_on;
  logic             odd_l;
  logic             last;
  logic             done;
  logic             par_bad;

  assign last    = (idx == (par_on ? IDX_W'(DATA_W + 1) : IDX_W'(DATA_W)));
  assign done    = tick && (st == RX_BITS) && (cnt == SUB_W'(OVS - 1)) && last;
  assign par_bad = par_on && (bits[DATA_W] != (^bits[DATA_W-1:0] ^ odd_l));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      idx    <= '0;
      bits   <= '0;
      par_on <= 1'b0;
      odd_l  <= 1'b0;
    end else if (tick) begin
      case (st)
        RX_IDLE: if (!lvl) begin
          st     <= RX_START;
          cnt    <= '0;
          par_on <= par_en;
          odd_l  <= par_odd;
        end
        RX_START: if (cnt == SUB_W'(HALF - 1)) begin
          cnt <= '0;
          idx <= '0;
          st  <= lvl ? RX_IDLE : RX_BITS;
        end else begin
          cnt <= cnt + 1'b1;
        end
        RX_BITS: if (cnt == SUB_W'(OVS - 1)) begin
          cnt <= '0;
          if (last) begin
            st <= RX_IDLE;
          end else begin
            bits[idx] <= lvl;
            idx       <= idx + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
    end else if (done && !(full && !pop)) begin
      data <= bits[DATA_W-1:0];
      full <= 1'b1;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe <= 1'b0;
      fe <= 1'b0;
      oe <= 1'b0;
    end else if (clr) begin
      pe <= 1'b0;
      fe <= 1'b0;
      oe <= 1'b0;
    end else if (done) begin
      if (full && !pop) begin
        oe <= 1'b1;
      end else begin
        fe <= fe | !lvl;
        pe <= pe | par_bad;
      end
    end
  end

  // R5: a held byte stays valid until taken
  p_valid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  // R8: a held byte is not overwritten, overrun or not
  p_overrun_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> $stable(data));
endmodule

// File: rtl/aser_port.sv
`timescale 1ns/1ps
module aser_port
  import aser_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        cfg,
  input  logic              tx_break,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              irq,
  output logic [15:0]       status
);
  logic [1:0] sy;
  logic       pin;
  logic       lvl;
  logic       tick;
  logic       line;
  logic       pe, fe, oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= 2'b11;
    else        sy <= {sy[0], ser_in};
  end

  assign pin = sy[1];
  assign lvl = pin ^ cfg[CF_RXINV];

  aser_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  aser_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .par_en(cfg[CF_PAREN]), .par_odd(cfg[CF_ODD]),
    .in_valid(tx_valid), .in_data(tx_data), .in_ready(tx_ready),
    .line(line)
  );

  aser_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .par_en(cfg[CF_PAREN]), .par_odd(cfg[CF_ODD]),
    .lvl(lvl), .pop(rx_ready), .clr(cfg[CF_CLRERR]),
    .data(rx_data), .full(rx_valid), .pe(pe), .fe(fe), .oe(oe)
  );

  assign ser_out = (tx_break ? 1'b0 : line) ^ cfg[CF_TXINV];
  assign irq     = (rx_valid && cfg[CF_RXIE]) || (tx_ready && cfg[CF_TXIE]);

  always_comb begin
    status         = '0;
    status[4:0]    = cfg[4:0];
    status[ST_RBF] = rx_valid;
    status[ST_TBE] = tx_ready;
    status[ST_PE]  = pe;
    status[ST_FE]  = fe;
    status[ST_OE]  = oe;
    status[ST_PIN] = pin;
    status[ST_BRK] = tx_break;
    status[ST_ERR] = pe | fe | oe;
  end

  // R9: the clear control wipes every error flag by the next cycle
  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[CF_CLRERR] |=> !status[ST_ERR]);
endmodule

// File: tb/aser_port_test.sv
`timescale 1ns/1ps
module aser_port_test;
  localparam int OVS = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  cfg;
  logic        tx_break;
  logic [15:0] baud_div;
  logic        tx_valid;
  logic        tx_ready;
  logic [7:0]  tx_data;
  logic        rx_valid;
  logic        rx_ready;
  logic [7:0]  rx_data;
  logic        ser_in;
  logic        ser_out;
  logic        irq;
  logic [15:0] status;

  int checks = 0;
  int errors = 0;
  int bp = 16;
  bit done = 0;

  always #2.5 clk = ~clk;

  aser_port #(.DIV_W(16), .DATA_W(8), .OVS(OVS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .tx_break(tx_break), .baud_div(baud_div),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .ser_in(ser_in), .ser_out(ser_out), .irq(irq), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic capture(input bit inv, input bit has_par,
                         output logic [7:0] d, output bit p, output bit stp);
    int t = 0;
    while (((ser_out ^ inv) !== 1'b0) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (bp / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (bp) @(negedge clk);
      d[i] = ser_out ^ inv;
    end
    p = 1'b0;
    if (has_par) begin
      repeat (bp) @(negedge clk);
      p = ser_out ^ inv;
    end
    repeat (bp) @(negedge clk);
    stp = ser_out ^ inv;
  endtask

  task automatic send(input logic [7:0] d, input bit par_en, input bit odd,
                      input bit bad_par, input bit bad_stop, input bit inv);
    @(negedge clk);
    ser_in = 1'b0 ^ inv;
    repeat (bp) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_in = d[i] ^ inv;
      repeat (bp) @(negedge clk);
    end
    if (par_en) begin
      ser_in = (^d) ^ odd ^ bad_par ^ inv;
      repeat (bp) @(negedge clk);
    end
    ser_in = (!bad_stop) ^ inv;
    repeat (bp) @(negedge clk);
    ser_in = 1'b1 ^ inv;
    repeat (bp) @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic clear_errs();
    @(negedge clk);
    cfg[6] = 1'b1;
    repeat (2) @(negedge clk);
    cfg[6] = 1'b0;
  endtask

  // per-cycle model checks, sampled 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n === 1'b1 && !done) begin
      chk(irq == ((rx_valid && cfg[5]) || (tx_ready && cfg[4])), "R12 irq", irq,
          (rx_valid && cfg[5]) || (tx_ready && cfg[4]));
      chk(status[15] == (|status[11:9]), "R9 summary", status[15], |status[11:9]);
      chk(status[4:0] == cfg[4:0], "R13 echo", status[4:0], cfg[4:0]);
      if (tx_break) chk(ser_out == cfg[2], "R11 break level", ser_out, cfg[2]);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] a;
    logic [7:0] b;
    bit p;
    bit s;
    bit p2;
    bit s2;
    rst_n = 1'b0; cfg = '0; tx_break = 1'b0; baud_div = 16'd1;
    tx_valid = 1'b0; tx_data = '0; rx_ready = 1'b0; ser_in = 1'b1;
    bp = OVS * 2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(status == 16'h2100, "R1 status", status, 16'h2100);
    chk(ser_out == 1'b1, "R1 ser_out", ser_out, 1);
    chk(irq == 1'b0 && rx_valid == 1'b0, "R1 irq/rx_valid", {irq, rx_valid}, 0);

    // R2 plain frame
    fork
      capture(1'b0, 1'b0, a, p, s);
      push(8'hA5);
    join
    chk(a == 8'hA5, "R2 data", a, 8'hA5);
    chk(s == 1'b1, "R2 stop", s, 1);

    // R3 even then odd parity
    cfg = 7'b0000010;
    fork
      capture(1'b0, 1'b1, a, p, s);
      push(8'h37);
    join
    chk(a == 8'h37 && p == 1'b1, "R3 even parity", {a, p}, {8'h37, 1'b1});
    cfg = 7'b0000011;
    fork
      capture(1'b0, 1'b1, a, p, s);
      push(8'h37);
    join
    chk(a == 8'h37 && p == 1'b0 && s == 1'b1, "R3 odd parity", {a, p, s}, {8'h37, 2'b01});
    cfg = '0;

    // R2 with a tick on every cycle
    baud_div = 16'd0; bp = OVS;
    fork
      capture(1'b0, 1'b0, a, p, s);
      push(8'h0F);
    join
    chk(a == 8'h0F && s == 1'b1, "R2 div0 frame", a, 8'h0F);
    baud_div = 16'd1; bp = OVS * 2;
    repeat (bp) @(negedge clk);

    // R4 back-to-back
    fork
      begin
        capture(1'b0, 1'b0, a, p, s);
        capture(1'b0, 1'b0, b, p2, s2);
      end
      begin
        push(8'h11);
        chk(tx_ready == 1'b0, "R4 buffer full", tx_ready, 0);
        @(negedge clk);
        chk(tx_ready == 1'b1, "R4 buffer freed", tx_ready, 1);
        push(8'h22);
      end
    join
    chk(a == 8'h11 && b == 8'h22, "R4 two bytes", {a, b}, 16'h1122);
    repeat (bp) @(negedge clk);

    // R5 receive
    send(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(rx_valid == 1'b1 && status[7] == 1'b1, "R5 valid", rx_valid, 1);
    chk(rx_data == 8'h5A, "R5 data", rx_data, 8'h5A);
    chk(status[11:9] == 3'b000, "R5 no errors", status[11:9], 0);
    pop();
    chk(rx_valid == 1'b0, "R5 popped", rx_valid, 0);

    // R6 parity
    cfg = 7'b0000010;
    send(8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(rx_data == 8'h3C && status[9] == 1'b0, "R6 good parity", {rx_data, status[9]}, {8'h3C, 1'b0});
    pop();
    send(8'h3C, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(status[9] == 1'b1, "R6 bad parity", status[9], 1);
    chk(status[15] == 1'b1, "R9 summary set", status[15], 1);
    pop();
    clear_errs();
    @(negedge clk);
    chk(status[11:9] == 3'b000 && status[15] == 1'b0, "R9 cleared", status[15:9], 0);
    cfg = '0;

    // R7 framing
    send(8'h81, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(status[10] == 1'b1 && rx_data == 8'h81, "R7 framing", {status[10], rx_data}, {1'b1, 8'h81});
    pop();
    clear_errs();

    // R8 overrun
    send(8'h12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'h34, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(status[11] == 1'b1, "R8 overrun flag", status[11], 1);
    chk(rx_data == 8'h12, "R8 old data kept", rx_data, 8'h12);
    chk(status[10:9] == 2'b00, "R8 only overrun", status[10:9], 0);
    pop();
    @(negedge clk);
    chk(rx_valid == 1'b0, "R8 new byte dropped", rx_valid, 0);
    clear_errs();

    // R10 output inversion
    cfg = 7'b0000100;
    @(negedge clk);
    chk(ser_out == 1'b0, "R10 inverted idle", ser_out, 0);
    fork
      capture(1'b1, 1'b0, a, p, s);
      push(8'hC3);
    join
    chk(a == 8'hC3 && s == 1'b1, "R10 inverted tx", a, 8'hC3);

    // R10 / R13 input inversion
    @(negedge clk);
    cfg = 7'b0001000; ser_in = 1'b0;
    repeat (bp * 2) @(negedge clk);
    chk(status[13] == 1'b0, "R13 raw pin level", status[13], 0);
    send(8'h96, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(rx_valid == 1'b1 && rx_data == 8'h96, "R10 inverted rx", rx_data, 8'h96);
    pop();
    cfg = '0; ser_in = 1'b1;
    repeat (bp * 2) @(negedge clk);
    chk(status[13] == 1'b1 && rx_valid == 1'b0, "R13 pin high", status[13], 1);

    // R11 break
    tx_break = 1'b1;
    @(negedge clk);
    chk(ser_out == 1'b0 && status[14] == 1'b1, "R11 break", {ser_out, status[14]}, 2'b01);
    cfg = 7'b0000100;
    @(negedge clk);
    chk(ser_out == 1'b1, "R11 break inverted", ser_out, 1);
    tx_break = 1'b0; cfg = '0;
    @(negedge clk);
    chk(status[14] == 1'b0 && ser_out == 1'b1, "R11 released", {status[14], ser_out}, 2'b01);

    // R12 interrupts
    cfg = 7'b0010000;
    @(negedge clk);
    chk(irq == 1'b1, "R12 tx empty irq", irq, 1);
    cfg = 7'b0100000;
    @(negedge clk);
    chk(irq == 1'b0, "R12 rx idle no irq", irq, 0);
    send(8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(irq == 1'b1, "R12 rx irq", irq, 1);
    pop();
    @(negedge clk);
    chk(irq == 1'b0, "R12 rx irq drops", irq, 0);

    // R13 echo
    cfg = 7'b0011111; ser_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(status[4:0] == 5'h1F && status[13] == 1'b0, "R13 echo", status, 16'h011F);
    cfg = '0; ser_in = 1'b1;
    repeat (bp * 2) @(negedge clk);
    chk(rx_valid == 1'b0, "R13 no spurious byte", rx_valid, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule